// File: doc/BRIEF.md
# Packed Rounding Q15 Multiplier

This block is a SIMD datapath that splits two source vectors into packed signed 16-bit lanes. In every lane it multiplies the pair, scales the product back into Q15 form with round-to-nearest, and places the 16-bit result in the matching lane of a new destination vector. The active vector length can be 128, 256 or 512 bits. Lanes above the active length are either cleared or carried over from the old destination value. The carry-over covers the two-operand form, where the first source also serves as the destination.

Each active lane can be gated by a per-lane write mask. When masking is on, a lane whose mask bit is clear either keeps the old destination lane (merge) or is forced to zero (zeroing). The result is registered. It appears one clock after an accepted input and is marked by a valid flag.

Top module: `q15_rmul_simd`

## Requirements
- R1: Each written lane equals bits 16 down to 1 of ((a*b) arithmetically shifted right by 14) + 1, where a and b are the signed 16-bit lane operands and the product is a signed 32-bit value.
- R2: A lane holding -32768 (0x8000) in both sources yields 0x8000. There is no saturation.
- R3: Lane j occupies bits j*16+15 down to j*16. len_sel 0 selects 8 active lanes, 1 selects 16 lanes, and 2 or 3 selects 32 lanes.
- R4: An active lane takes the computed product when mask_en is 0, or when its mask bit (mask[j]) is 1.
- R5: With mask_en 1 and zero_mode 0, an active lane whose mask bit is 0 keeps the value of the same lane of dst_old.
- R6: With mask_en 1 and zero_mode 1, an active lane whose mask bit is 0 becomes 0x0000.
- R7: Mask bits at positions equal to or above the active lane count have no effect on dst_new.
- R8: With keep_upper 0, every lane above the active length is 0 in dst_new.
- R9: With keep_upper 1, every lane above the active length equals the same lane of dst_old. The caller drives dst_old with src_a for the two-operand form.
- R10: out_valid is 0 in the cycle after reset is asserted. An accepted input (in_valid 1) gives out_valid 1 and its dst_new on the next clock edge. When in_valid is 0, out_valid is 0 on the next edge and dst_new holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands present this cycle |
| len_sel | input | 2 | Active length: 0=128, 1=256, 2/3=512 bits |
| keep_upper | input | 1 | Lanes above active length copy dst_old instead of clearing |
| mask_en | input | 1 | Enable per-lane write mask |
| zero_mode | input | 1 | Masked-off lanes: 1 = zero, 0 = merge |
| mask | input | 32 | Per-lane mask, bit j for lane j |
| src_a | input | 512 | First source vector |
| src_b | input | 512 | Second source vector |
| dst_old | input | 512 | Prior destination value |
| out_valid | output | 1 | dst_new carries a fresh result |
| dst_new | output | 512 | Registered result vector |

## Verification
Mask bits above the active lane count are the hardest case to reach. They matter only when the length is short and the mask is long, so random stimulus rarely separates a design that ignores them from one that does not. The bench therefore applies masks whose low lanes are clear and whose upper bits are set, at the 128-bit and 256-bit lengths, in both merge and zeroing modes. Any leakage then shows up in the cleared upper lanes. The -32768 squared wrap is also forced into every lane, because random operands almost never hit it.

// File: rtl/q15_pkg.sv
package q15_pkg;
  localparam int LANE_W = 16;
  localparam int BASE_LANES = 8;

  typedef enum logic [1:0] {
    VL_SHORT = 2'd0,
    VL_MID   = 2'd1,
    VL_LONG  = 2'd2,
    VL_ALT   = 2'd3
  } vlen_e;

  function automatic int lanes_for(input logic [1:0] sel, input int base, input int max_lanes);
    int n;
    n = base << sel;
    if (n > max_lanes) n = max_lanes;
    return n;
  endfunction
endpackage

// File: rtl/q15_lane_mul.sv
module q15_lane_mul #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] r
);
  localparam int PW = 2 * W;

  logic signed [PW-1:0] prod;
  logic [W-1:0]         mid;
  logic                 rbit;
  logic                 unused_top;
  logic [W-3:0]         unused_low;

  assign prod = $signed({{W{a[W-1]}}, a}) * $signed({{W{b[W-1]}}, b});
  assign {unused_top, mid, rbit, unused_low} = prod;
  // shift by W-2, add one, drop the LSB == high part plus rounding bit
  assign r = mid + {{(W-1){1'b0}}, rbit};
endmodule

// File: rtl/q15_len_dec.sv
module q15_len_dec import q15_pkg::*; #(
  parameter int MAX_LANES = 32,
  parameter int BASE      = 8
) (
  input  logic [1:0]           len_sel,
  output logic [MAX_LANES-1:0] lane_on
);
  always_comb begin
    int n;
    n = lanes_for(len_sel, BASE, MAX_LANES);
    for (int j = 0; j < MAX_LANES; j++) lane_on[j] = (j < n);
  end
endmodule

// File: rtl/q15_lane_sel.sv
module q15_lane_sel #(
  parameter int W = 16
) (
  input  logic [W-1:0] prod,
  input  logic [W-1:0] old,
  input  logic         on,
  input  logic         mbit,
  input  logic         mask_en,
  input  logic         zero_mode,
  input  logic         keep_upper,
  output logic [W-1:0] nxt
);
  always_comb begin
    if (!on)                    nxt = keep_upper ? old : '0;
    else if (!mask_en || mbit)  nxt = prod;
    else if (zero_mode)         nxt = '0;
    else                        nxt = old;
  end
endmodule

// File: rtl/q15_rmul_simd.sv
module q15_rmul_simd import q15_pkg::*; #(
  parameter int LW        = LANE_W,
  parameter int MAX_LANES = 32,
  parameter int BASE      = BASE_LANES,
  localparam int VEC_W    = LW * MAX_LANES
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [1:0]           len_sel,
  input  logic                 keep_upper,
  input  logic                 mask_en,
  input  logic                 zero_mode,
  input  logic [MAX_LANES-1:0] mask,
  input  logic [VEC_W-1:0]     src_a,
  input  logic [VEC_W-1:0]     src_b,
  input  logic [VEC_W-1:0]     dst_old,
  output logic                 out_valid,
  output logic [VEC_W-1:0]     dst_new
);
  logic [MAX_LANES-1:0] lane_on;
  logic [VEC_W-1:0]     next_vec;

  q15_len_dec #(.MAX_LANES(MAX_LANES), .BASE(BASE)) u_len (
    .len_sel (len_sel),
    .lane_on (lane_on)
  );

  for (genvar j = 0; j < MAX_LANES; j++) begin : g_lane
    logic [LW-1:0] p;
    q15_lane_mul #(.W(LW)) u_mul (
      .a (src_a[j*LW +: LW]),
      .b (src_b[j*LW +: LW]),
      .r (p)
    );
    q15_lane_sel #(.W(LW)) u_sel (
      .prod       (p),
      .old        (dst_old[j*LW +: LW]),
      .on         (lane_on[j]),
      .mbit       (mask[j]),
      .mask_en    (mask_en),
      .zero_mode  (zero_mode),
      .keep_upper (keep_upper),
      .nxt        (next_vec[j*LW +: LW])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid) dst_new <= next_vec;
  end
endmodule

// File: rtl/q15_rmul_chk.sv
module q15_rmul_chk #(
  parameter int LW        = 16,
  parameter int MAX_LANES = 32,
  localparam int VEC_W    = LW * MAX_LANES
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic [1:0]           len_sel,
  input logic                 keep_upper,
  input logic                 mask_en,
  input logic                 zero_mode,
  input logic [MAX_LANES-1:0] mask,
  input logic [VEC_W-1:0]     src_a,
  input logic [VEC_W-1:0]     src_b,
  input logic [VEC_W-1:0]     dst_old,
  input logic                 out_valid,
  input logic [VEC_W-1:0]     dst_new
);
  AST_RST_CLEAR: assert property (@(posedge clk) rst |=> !out_valid); // R10
  AST_VALID_LAT: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R10
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(dst_new))); // R10
  AST_MIN_WRAP: assert property (@(posedge clk) disable iff (rst)
    (in_valid && src_a[LW-1:0] == 16'h8000 && src_b[LW-1:0] == 16'h8000 && (!mask_en || mask[0]))
    |=> dst_new[LW-1:0] == 16'h8000); // R2
  AST_MERGE_KEEP: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mask_en && !zero_mode && !mask[0])
    |=> dst_new[LW-1:0] == $past(dst_old[LW-1:0])); // R5
  AST_ZERO_LANE: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mask_en && zero_mode && !mask[0]) |=> dst_new[LW-1:0] == '0); // R6
  AST_UPPER_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (in_valid && len_sel == 2'd0 && !keep_upper) |=> dst_new[VEC_W-1:8*LW] == '0); // R8
  AST_UPPER_KEEP: assert property (@(posedge clk) disable iff (rst)
    (in_valid && len_sel == 2'd0 && keep_upper)
    |=> dst_new[VEC_W-1:8*LW] == $past(dst_old[VEC_W-1:8*LW])); // R9
endmodule

bind q15_rmul_simd q15_rmul_chk #(.LW(LW), .MAX_LANES(MAX_LANES)) u_chk (.*);

// File: tb/q15_rmul_simd_tb.sv
module q15_rmul_simd_tb;
  localparam int CLK_P = 10;
  localparam int NL = 32;
  localparam int VW = 16 * NL;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [1:0] len_sel = 2'd0;
  logic keep_upper = 1'b0, mask_en = 1'b0, zero_mode = 1'b0;
  logic [NL-1:0] mask = '0;
  logic [VW-1:0] src_a = '0, src_b = '0, dst_old = '0;
  logic out_valid;
  logic [VW-1:0] dst_new;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  q15_rmul_simd u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .len_sel(len_sel),
    .keep_upper(keep_upper), .mask_en(mask_en), .zero_mode(zero_mode),
    .mask(mask), .src_a(src_a), .src_b(src_b), .dst_old(dst_old),
    .out_valid(out_valid), .dst_new(dst_new)
  );

  function automatic int n_lanes(input logic [1:0] s);
    return (s == 2'd0) ? 8 : (s == 2'd1) ? 16 : 32;
  endfunction

  function automatic logic [15:0] ref_lane(input logic [15:0] a, input logic [15:0] b);
    longint p, t;
    p = longint'($signed(a)) * longint'($signed(b));
    t = (p >>> 14) + 1;
    return 16'((t >> 1) & 64'hFFFF);
  endfunction

  function automatic logic [VW-1:0] ref_vec();
    logic [VW-1:0] v;
    int n;
    n = n_lanes(len_sel);
    for (int j = 0; j < NL; j++) begin
      logic [15:0] o;
      o = dst_old[j*16 +: 16];
      if (j >= n)                   v[j*16 +: 16] = keep_upper ? o : 16'h0;
      else if (!mask_en || mask[j]) v[j*16 +: 16] = ref_lane(src_a[j*16 +: 16], src_b[j*16 +: 16]);
      else if (zero_mode)           v[j*16 +: 16] = 16'h0;
      else                          v[j*16 +: 16] = o;
    end
    return v;
  endfunction

  function automatic logic [VW-1:0] rnd_vec();
    logic [VW-1:0] v;
    for (int k = 0; k < VW/32; k++) v[k*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic check_vec(input string tag, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_bit(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // inputs already set at a negedge; accept on next posedge, sample at following negedge
  task automatic run_op(input string tag);
    logic [VW-1:0] e;
    in_valid = 1'b1;
    e = ref_vec();
    @(negedge clk);
    in_valid = 1'b0;
    check_bit({tag, " valid"}, out_valid, 1'b1);
    check_vec(tag, dst_new, e);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_bit("R10 reset clears valid", out_valid, 1'b0);
    rst = 1'b0;
    @(negedge clk);

    // R2: extreme negative squared in every lane
    len_sel = 2'd2; src_a = {NL{16'h8000}}; src_b = {NL{16'h8000}};
    run_op("R2 min times min");
    check_vec("R2 lane0 is 0x8000", {{(VW-16){1'b0}}, dst_new[15:0]}, {{(VW-16){1'b0}}, 16'h8000});

    // R1/R3 directed values: 0.5*0.5, -1*0.5, 1 lsb cases
    src_a = rnd_vec(); src_b = rnd_vec();
    src_a[15:0] = 16'h4000; src_b[15:0] = 16'h4000;
    src_a[31:16] = 16'h8000; src_b[31:16] = 16'h4000;
    src_a[47:32] = 16'h0001; src_b[47:32] = 16'h4000;
    src_a[63:48] = 16'hFFFF; src_b[63:48] = 16'h4000;
    run_op("R1 directed lanes");

    // R10: idle input leaves output untouched
    begin
      logic [VW-1:0] held;
      held = dst_new;
      src_a = rnd_vec(); src_b = rnd_vec(); dst_old = rnd_vec();
      @(negedge clk);
      check_bit("R10 idle valid low", out_valid, 1'b0);
      check_vec("R10 idle hold", dst_new, held);
    end

    // R3/R8 each length, unmasked
    for (int s = 0; s < 4; s++) begin
      len_sel = 2'(s); mask_en = 0; keep_upper = 0;
      src_a = rnd_vec(); src_b = rnd_vec(); dst_old = rnd_vec();
      run_op("R3 R8 length unmasked");
    end

    // R4/R5/R6 fixed mask patterns in both modes at each length
    for (int s = 0; s < 3; s++) begin
      for (int zm = 0; zm < 2; zm++) begin
        for (int pi = 0; pi < 4; pi++) begin
          len_sel = 2'(s); mask_en = 1; zero_mode = zm[0]; keep_upper = 0;
          mask = (pi == 0) ? 32'h0 : (pi == 1) ? 32'hFFFFFFFF : (pi == 2) ? 32'h55555555 : 32'hA5C3F00F;
          src_a = rnd_vec(); src_b = rnd_vec(); dst_old = rnd_vec();
          run_op(zm ? "R4 R6 zeroing mask" : "R4 R5 merge mask");
        end
      end
    end

    // R7: only bits above the active count set
    for (int s = 0; s < 2; s++) begin
      for (int zm = 0; zm < 2; zm++) begin
        len_sel = 2'(s); mask_en = 1; zero_mode = zm[0]; keep_upper = 0;
        mask = (s == 0) ? 32'hFFFFFF00 : 32'hFFFF0000;
        src_a = rnd_vec(); src_b = rnd_vec(); dst_old = rnd_vec();
        run_op("R7 high mask bits ignored");
      end
    end

    // R9: two-operand form, destination is first source, upper kept
    for (int s = 0; s < 3; s++) begin
      len_sel = 2'(s); mask_en = 0; keep_upper = 1;
      src_a = rnd_vec(); src_b = rnd_vec(); dst_old = src_a;
      run_op("R9 keep upper lanes");
    end

    // R1/R4/R5/R6/R8/R9 random sweep
    for (int i = 0; i < 300; i++) begin
      len_sel = 2'($urandom_range(0, 3));
      mask_en = 1'($urandom); zero_mode = 1'($urandom); keep_upper = 1'($urandom);
      mask = $urandom;
      src_a = rnd_vec(); src_b = rnd_vec(); dst_old = rnd_vec();
      if (i % 7 == 0) src_b[16*($urandom_range(0, 31)) +: 16] = 16'h8000;
      run_op("R1 R4 R5 R6 R8 R9 random");
    end

    // R10: reset mid-stream
    in_valid = 1'b1; rst = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; rst = 1'b0;
    check_bit("R10 reset over valid", out_valid, 1'b0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog R10: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule